// File: doc/BRIEF.md
# Two-Tone Table-Stepped FSK Modulator

This block turns a serial bit stream, such as the transmit line of a UART, into a stream of 8-bit unsigned sine samples for an external DAC. A 64-entry sine table is built when the design is elaborated. An index walks through the table, one entry per sample strobe. Two sample strobes are derived from the system clock by fractional accumulator dividers. The data bit picks which strobe moves the index, so the tone the DAC plays depends on the current bit.

The index is never cleared when the data bit changes. The waveform therefore continues from the same point in its cycle whichever tone follows. With the default divider settings and a 100 MHz clock, a 0 bit steps the table at 134.4 kHz (a 2100 Hz tone) and a 1 bit steps it at 83.2 kHz (a 1300 Hz tone). Each new sample comes with a one-cycle valid pulse. When the enable is low, the output rests at mid-scale.

Top module: `fsk_table_mod`

## Requirements
- R1: The table has DEPTH=64 entries of DATA_W=8 bits, entry k being round(128 + 127*sin(2*pi*k/64)); entry 0 is 0x80, entry 16 is 0xFF (255) and entry 48 is 0x01.
- R2: Each tone strobe fires at f_clk*STEP/MOD; the tone frequency is that rate divided by 64 (defaults STEP0=1344, STEP1=832, MOD=1000000 give 134.4 kHz and 83.2 kHz from 100 MHz, so 2100 Hz and 1300 Hz).
- R3: A synchronized data bit of 0 lets only the tone-0 strobe advance the index, and a 1 lets only the tone-1 strobe advance it; the bit passes through a two-flop synchronizer first.
- R4: Every active strobe moves the index forward by exactly one entry, and the index wraps from 63 to 0.
- R5: A change of the data bit leaves the index where it is, so the sample sequence continues without a jump.
- R6: The sample output changes only on an active strobe, and valid_o pulses high for exactly one cycle with each new sample.
- R7: While en_i is low, sample_o is 0x80 and valid_o is low, and the index and both divider accumulators keep their values; when en_i returns, the next sample is the table entry that would have come next.
- R8: A synchronous reset sets sample_o to 0x80, valid_o low, the index to 0 and the accumulators to 0, so the first sample after reset is entry 0.
- R9: Each divider keeps a remainder, so consecutive strobes are floor(MOD/STEP) or ceil(MOD/STEP) cycles apart and never on adjacent cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enables stepping; when low the output holds mid-scale |
| bit_i | input | 1 | Asynchronous data bit that selects the tone |
| sample_o | output | DATA_W | Unsigned sine sample for the DAC |
| valid_o | output | 1 | One-cycle pulse marking a new sample |

## Verification
Some properties are checked on every cycle: the accumulator remainder stays below the modulus, strobes and valid pulses never fall on adjacent cycles, the index moves by one (with wrap) only on an active strobe and holds otherwise, the sample holds between strobes, and a low enable forces mid-scale with no valid pulse. Other behaviour shows only in the bench scenarios: the sample values compared with an independent sine model, the strobe spacing that reveals which tone is selected, phase continuity across bit changes and across a disable window, and the restart from entry 0 after a reset in the middle of a run.

// File: rtl/fsk_mod_pkg.sv
package fsk_mod_pkg;

  localparam real TWO_PI = 6.283185307179586;
  localparam real HALF_TURN = 3.141592653589793;

  // Sine of an angle by power series after folding it into [-pi, pi].
  function automatic real series_sin(input real ang);
    real x;
    real term;
    real acc;
    x = ang;
    while (x > HALF_TURN) x = x - TWO_PI;
    while (x < -HALF_TURN) x = x + TWO_PI;
    term = x;
    acc = x;
    for (int n = 1; n < 16; n++) begin
      term = -term * x * x / ((2.0 * n) * (2.0 * n + 1.0));
      acc = acc + term;
    end
    return acc;
  endfunction

  // Unsigned table entry k of a depth-entry table of width-bit samples.
  function automatic int sine_point(input int k, input int depth, input int width);
    real amp;
    real mid;
    real v;
    mid = real'(1 << (width - 1));
    amp = mid - 1.0;
    v = mid + amp * series_sin(TWO_PI * real'(k) / real'(depth)) + 0.5;
    return int'($floor(v));
  endfunction

endpackage

// File: rtl/fsk_bit_sync.sv
module fsk_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/fsk_frac_strobe.sv
module fsk_frac_strobe #(
  parameter int unsigned STEP = 1344,
  parameter int unsigned MOD  = 1000000
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic tick_o
);
  localparam int ACC_W = $clog2(2 * MOD);
  localparam logic [ACC_W-1:0] STEP_V = ACC_W'(STEP);
  localparam logic [ACC_W-1:0] MOD_V  = ACC_W'(MOD);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;

  assign sum = acc_q + STEP_V;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else if (en_i) begin
      if (sum >= MOD_V) begin
        acc_q  <= sum - MOD_V;
        tick_o <= 1'b1;
      end else begin
        acc_q  <= sum;
        tick_o <= 1'b0;
      end
    end else begin
      tick_o <= 1'b0;
    end
  end

  // R9: the remainder never reaches the modulus
  a_r9_acc_below_mod: assert property (@(posedge clk) disable iff (rst)
    acc_q < MOD_V);
  // R9: a rate of at most half the clock gives isolated ticks
  a_r9_tick_isolated: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
  // R7: the accumulator is frozen while disabled
  a_r7_acc_frozen: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(acc_q));
endmodule

// File: rtl/fsk_sine_rom.sv
module fsk_sine_rom
  import fsk_mod_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] q_o
);
  localparam logic [DATA_W-1:0] MID = DATA_W'(1 << (DATA_W - 1));

  logic [DATA_W-1:0] tbl [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      assign tbl[g] = DATA_W'(sine_point(g, DEPTH, DATA_W));
    end
  endgenerate

  // Registered read with a synchronous set to mid-scale.
  always_ff @(posedge clk) begin
    if (rst || clr_i) q_o <= MID;
    else if (rd_i)    q_o <= tbl[addr_i];
  end
endmodule

// File: rtl/fsk_table_mod.sv
module fsk_table_mod #(
  parameter int          DATA_W      = 8,
  parameter int          DEPTH       = 64,
  parameter int unsigned STEP0       = 1344,
  parameter int unsigned STEP1       = 832,
  parameter int unsigned MOD         = 1000000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] sample_o,
  output logic              valid_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);
  localparam logic [DATA_W-1:0] MID = DATA_W'(1 << (DATA_W - 1));

  logic             bit_s;
  logic [1:0]       tick;
  logic             adv;
  logic [IDX_W-1:0] idx_q;

  fsk_bit_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d_i (bit_i),
    .q_o (bit_s)
  );

  generate
    for (genvar t = 0; t < 2; t++) begin : g_tone
      fsk_frac_strobe #(
        .STEP ((t == 0) ? STEP0 : STEP1),
        .MOD  (MOD)
      ) i_div (
        .clk    (clk),
        .rst    (rst),
        .en_i   (en_i),
        .tick_o (tick[t])
      );
    end
  endgenerate

  assign adv = en_i && tick[bit_s];

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= adv;
      if (adv) idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
    end
  end

  fsk_sine_rom #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_rom (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (!en_i),
    .rd_i   (adv),
    .addr_i (idx_q),
    .q_o    (sample_o)
  );

  // R4: one step per active strobe, wrapping at the end
  a_r4_index_step: assert property (@(posedge clk) disable iff (rst)
    adv |=> (idx_q == (($past(idx_q) == LAST) ? '0 : $past(idx_q) + 1'b1)));
  // R5: no strobe, no index movement (a bit change alone never moves it)
  a_r5_index_hold: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(idx_q));
  // R6: valid is a single-cycle pulse
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  // R6: the sample holds between strobes while enabled
  a_r6_sample_hold: assert property (@(posedge clk) disable iff (rst)
    (en_i && !adv) |=> $stable(sample_o));
  // R7: disabled output rests at mid-scale with no pulse
  a_r7_off_mid: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (sample_o == MID && !valid_o));
endmodule

// File: tb/test_fsk_table_mod.sv
module test_fsk_table_mod;
  localparam int DEPTH = 64;
  localparam int STEP0 = 21;
  localparam int STEP1 = 13;
  localparam int MOD   = 210;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_i = 1'b1;
  logic       bit_i = 1'b0;
  logic [7:0] sample_o;
  logic       valid_o;

  int total = 0;
  int bad = 0;
  int model_k = 0;
  int cycles = 0;
  bit timed_out = 1'b0;

  always #5 clk = ~clk;

  fsk_table_mod #(
    .DATA_W(8), .DEPTH(DEPTH), .STEP0(STEP0), .STEP1(STEP1),
    .MOD(MOD), .SYNC_STAGES(2)
  ) i_fsk_table_mod (
    .clk(clk), .rst(rst), .en_i(en_i), .bit_i(bit_i),
    .sample_o(sample_o), .valid_o(valid_o)
  );

  // {bit, samples, min gap, max gap}
  localparam int NVEC = 5;
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b0, 7'd70, 8'd10, 8'd10},
    {1'b1, 7'd20, 8'd16, 8'd17},
    {1'b0, 7'd12, 8'd10, 8'd10},
    {1'b1, 7'd8,  8'd16, 8'd17},
    {1'b0, 7'd6,  8'd10, 8'd10}
  };

  function automatic int expect_val(input int k);
    real a;
    a = 2.0 * 3.141592653589793 * real'(k % DEPTH) / real'(DEPTH);
    return int'($floor(128.0 + 127.0 * $sin(a) + 0.5));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_sample(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!valid_o && gap < 1000);
  endtask

  task automatic check_sample(input string req);
    int e;
    e = expect_val(model_k);
    check(sample_o == 8'(e), req, sample_o, e);
    model_k++;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cycles++;
      if (cycles > 20000) begin
        timed_out = 1'b1;
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int gap;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    check(sample_o == 8'h80, "R8 reset sample", sample_o, 128);
    check(valid_o == 1'b0, "R8 reset valid", valid_o, 0);

    for (int v = 0; v < NVEC; v++) begin
      bit_i = VEC[v][23];
      for (int s = 0; s < int'(VEC[v][22:16]); s++) begin
        wait_sample(gap);
        if (v == 0 && s == 0) check_sample("R8 first entry");
        else if (s < 2) check_sample("R5 continuity");
        else if (model_k % DEPTH == 0) check_sample("R4 wrap");
        else if (model_k == 16 || model_k == 48) check_sample("R1 peak");
        else check_sample("R1 value");
        if (s >= 2) begin
          // R2/R3/R9: strobe spacing shows the selected tone
          check(gap >= int'(VEC[v][15:8]) && gap <= int'(VEC[v][7:0]),
                VEC[v][23] ? "R3 R9 tone1 gap" : "R2 R3 tone0 gap",
                gap, int'(VEC[v][15:8]));
        end
      end
    end

    // R7: disable holds mid-scale, no pulses
    @(negedge clk);
    en_i = 1'b0;
    @(negedge clk);
    begin
      bit quiet;
      quiet = 1'b1;
      for (int c = 0; c < 40; c++) begin
        if (sample_o != 8'h80 || valid_o) quiet = 1'b0;
        @(negedge clk);
      end
      check(quiet, "R7 disabled mid-scale", sample_o, 128);
    end
    en_i = 1'b1;
    wait_sample(gap);
    check_sample("R7 resume continuity");
    wait_sample(gap);
    check_sample("R6 next sample");
    // R6: valid lasts one cycle
    @(negedge clk);
    check(valid_o == 1'b0, "R6 valid width", valid_o, 0);

    // R8: reset in mid-run restarts at entry 0
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_k = 0;
    bit_i = 1'b0;
    wait_sample(gap);
    check_sample("R8 restart entry0");
    wait_sample(gap);
    check_sample("R4 step after restart");

    if (!timed_out) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule